// File: doc/BRIEF.md
# Trimmed Real-Time Second Generator

This block counts cycles of a free-running real-time clock, nominally 2^NOM_LOG2 Hz (32768 Hz by default), and marks one-second boundaries. The rate is trimmed digitally. A rate term, built from a coarse field and a two-bit fine field, gives the exact number of input cycles in eight consecutive seconds. A three-bit fractional accumulator spreads that total over the eight seconds, so the average rate can be moved in steps of one eighth of a cycle per second. That step is about 3.8 ppm at 32768 Hz, and the usable span is roughly ±1000 ppm.

At every boundary the block emits a one-cycle pulse and advances a seconds counter. It also reloads a sub-second countdown, which reports how many 1/256-second nominal ticks are left in the current second. Software can restart that countdown at any time. Writes to the trim fields and to the seconds counter are held in staging registers and take effect only at the next boundary. A sleep input makes every second nominal, while the trim values stay in place.

Top module: `rtcTrimSecond`

## Requirements
- R1: With a constant trim and sleep low, any eight consecutive seconds together last exactly T input cycles, where T = 4·coarse + fine, formed as the concatenation {coarse, fine}.
- R2: Each single second lasts either floor(T/8) or floor(T/8)+1 input cycles.
- R3: After reset the active coarse value is 2^(NOM_LOG2+1) (0x10000 by default) and fine is 0. The seconds count is 0, the sub-second count is 255, the pulse is low, and the first pulse arrives 2^NOM_LOG2 cycles after reset is released.
- R4: `secPulse` is high for exactly one cycle at each boundary, and the spacing between pulses equals the length of the second just ended.
- R5: A trim write leaves `trimCoarse`/`trimFine` and the length of the second in progress unchanged. The new values appear on those outputs at the next boundary and set the seconds that follow it.
- R6: A seconds write leaves `secCount` unchanged until the next boundary. At that boundary `secCount` loads the written value instead of incrementing. Later boundaries increment it.
- R7: `subSec` is 255 in the cycle of the pulse. It then decreases by one every 2^(NOM_LOG2-8) cycles and holds at 0 if the second outlasts the nominal length.
- R8: A `subRestart` strobe sets `subSec` to 255 and restarts its tick prescaler. It does not move the next boundary.
- R9: While `sleepMode` is high at a boundary, the second that follows lasts exactly 2^NOM_LOG2 cycles. The trim outputs keep their values, and the fractional remainder is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Real-time input clock |
| rstN | input | 1 | Active-low synchronous reset |
| sleepMode | input | 1 | Forces nominal seconds while high |
| trimWr | input | 1 | One-cycle strobe that stages a trim write |
| trimCoarseWr | input | NOM_LOG2+2 | Coarse trim value to stage |
| trimFineWr | input | 2 | Fine trim value to stage |
| secWr | input | 1 | One-cycle strobe that stages a seconds write |
| secWrData | input | SEC_W | Seconds value to stage |
| subRestart | input | 1 | Restarts the sub-second countdown |
| secPulse | output | 1 | One-cycle pulse per second boundary |
| secCount | output | SEC_W | Seconds counter |
| subSec | output | 8 | Remaining 1/256-second ticks in the current second |
| trimCoarse | output | NOM_LOG2+2 | Active coarse trim |
| trimFine | output | 2 | Active fine trim |

## Verification
The hardest state to reach is a second longer than nominal, long enough that the sub-second countdown sits at zero before the boundary arrives. Uncorrected seconds never get there. The bench runs with NOM_LOG2 = 9 so that eight-second windows stay short. It commits a term of 4104, which makes every second one cycle longer than nominal, and samples the last cycle before the pulse. The fractional spread is also hard to expose from outside. It is reached by committing terms whose low three bits are nonzero, both directed and random, and then summing and bounding each of the eight second lengths that follow the commit.

// File: rtl/rtcTrimPkg.sv
package rtcTrimPkg;

  // strobes from control to datapath, valid in the boundary cycle or any cycle
  typedef struct packed {
    logic takeSec;      // load staged seconds value at this boundary
    logic restartSub;   // restart sub-second countdown
    logic nominalRate;  // next second uses the untrimmed length
  } rtcStrobe_t;

  localparam int SUB_LOG2 = 8;
  localparam logic [SUB_LOG2-1:0] SUB_MAX = '1;

endpackage

// File: rtl/rtcTrimCtrl.sv
module rtcTrimCtrl
  import rtcTrimPkg::*;
#(
  parameter int NOM_LOG2 = 15,
  parameter int SEC_W    = 32,
  localparam int COARSE_W = NOM_LOG2 + 2,
  localparam int TERM_W   = COARSE_W + 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sleepMode,
  input  logic                trimWr,
  input  logic [COARSE_W-1:0] trimCoarseWr,
  input  logic [1:0]          trimFineWr,
  input  logic                secWr,
  input  logic [SEC_W-1:0]    secWrData,
  input  logic                subRestart,
  input  logic                atBoundary,
  output rtcStrobe_t          strobe,
  output logic [TERM_W-1:0]   nextTerm,
  output logic [SEC_W-1:0]    pendSec,
  output logic [COARSE_W-1:0] trimCoarse,
  output logic [1:0]          trimFine
);

  localparam logic [COARSE_W-1:0] COARSE_RST = COARSE_W'(1) << (NOM_LOG2 + 1);

  logic                pendTrimValid;
  logic [COARSE_W-1:0] pendCoarse;
  logic [1:0]          pendFine;
  logic                pendSecValid;
  logic [COARSE_W-1:0] activeCoarse;
  logic [1:0]          activeFine;
  logic [COARSE_W-1:0] selCoarse;
  logic [1:0]          selFine;

  // staging of trim writes; a write in the boundary cycle waits for the next one
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendTrimValid <= 1'b0;
      pendCoarse    <= COARSE_RST;
      pendFine      <= 2'd0;
    end else if (trimWr) begin
      pendTrimValid <= 1'b1;
      pendCoarse    <= trimCoarseWr;
      pendFine      <= trimFineWr;
    end else if (atBoundary) begin
      pendTrimValid <= 1'b0;
    end
  end

  // active trim, changes only at a boundary
  always_ff @(posedge clk) begin
    if (!rstN) begin
      activeCoarse <= COARSE_RST;
      activeFine   <= 2'd0;
    end else if (atBoundary && pendTrimValid) begin
      activeCoarse <= pendCoarse;
      activeFine   <= pendFine;
    end
  end

  // staging of seconds writes
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendSecValid <= 1'b0;
      pendSec      <= '0;
    end else if (secWr) begin
      pendSecValid <= 1'b1;
      pendSec      <= secWrData;
    end else if (atBoundary) begin
      pendSecValid <= 1'b0;
    end
  end

  // term used for the second that starts at the coming boundary
  always_comb begin
    selCoarse = pendTrimValid ? pendCoarse : activeCoarse;
    selFine   = pendTrimValid ? pendFine   : activeFine;
    nextTerm  = {selCoarse, selFine};
  end

  always_comb begin
    strobe.takeSec     = atBoundary & pendSecValid;
    strobe.restartSub  = subRestart;
    strobe.nominalRate = sleepMode;
  end

  assign trimCoarse = activeCoarse;
  assign trimFine   = activeFine;

  // R5
  trim_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !atBoundary |=> $stable({trimCoarse, trimFine}));

  // R9
  sleep_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sleepMode && !trimWr && !pendTrimValid) |=> $stable({trimCoarse, trimFine}));

endmodule

// File: rtl/rtcTrimDatapath.sv
module rtcTrimDatapath
  import rtcTrimPkg::*;
#(
  parameter int NOM_LOG2 = 15,
  parameter int SEC_W    = 32,
  localparam int TERM_W  = NOM_LOG2 + 4,
  localparam int CYC_W   = NOM_LOG2 + 2,
  localparam int PRE_W   = NOM_LOG2 - SUB_LOG2
) (
  input  logic                clk,
  input  logic                rstN,
  input  rtcStrobe_t          strobe,
  input  logic [TERM_W-1:0]   nextTerm,
  input  logic [SEC_W-1:0]    pendSec,
  output logic                atBoundary,
  output logic                secPulse,
  output logic [SEC_W-1:0]    secCount,
  output logic [SUB_LOG2-1:0] subSec
);

  localparam logic [CYC_W-1:0] NOM_LAST = CYC_W'((1 << NOM_LOG2) - 1);
  localparam logic [PRE_W-1:0] PRE_LAST = '1;

  logic [2:0]        fracAcc;
  logic [CYC_W-1:0]  cycCnt;
  logic [TERM_W:0]   sumTerm;
  logic [CYC_W-1:0]  nextLen;
  logic [PRE_W-1:0]  preCnt;

  assign atBoundary = (cycCnt == '0);

  // eighths of a cycle carried from second to second
  always_comb begin
    sumTerm = {1'b0, nextTerm} + {{(TERM_W - 2){1'b0}}, fracAcc};
    nextLen = sumTerm[TERM_W:3];
  end

  // period counter and fractional remainder
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cycCnt  <= NOM_LAST;
      fracAcc <= 3'd0;
    end else if (atBoundary) begin
      if (strobe.nominalRate) begin
        cycCnt <= NOM_LAST;
      end else begin
        cycCnt  <= nextLen - CYC_W'(1);
        fracAcc <= sumTerm[2:0];
      end
    end else begin
      cycCnt <= cycCnt - CYC_W'(1);
    end
  end

  // boundary pulse and seconds counter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      secPulse <= 1'b0;
      secCount <= '0;
    end else begin
      secPulse <= atBoundary;
      if (atBoundary) begin
        secCount <= strobe.takeSec ? pendSec : secCount + SEC_W'(1);
      end
    end
  end

  // sub-second countdown at the nominal tick rate
  always_ff @(posedge clk) begin
    if (!rstN) begin
      subSec <= SUB_MAX;
      preCnt <= '0;
    end else if (atBoundary || strobe.restartSub) begin
      subSec <= SUB_MAX;
      preCnt <= '0;
    end else if (preCnt == PRE_LAST) begin
      preCnt <= '0;
      if (subSec != '0) subSec <= subSec - SUB_LOG2'(1);
    end else begin
      preCnt <= preCnt + PRE_W'(1);
    end
  end

  // R4
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    secPulse |=> !secPulse);

  // R7
  sub_reload_chk: assert property (@(posedge clk) disable iff (!rstN)
    secPulse |-> (subSec == SUB_MAX));

  // R7
  sub_monotone_chk: assert property (@(posedge clk) disable iff (!rstN)
    (subSec != $past(subSec)) |->
      ((subSec == $past(subSec) - SUB_LOG2'(1)) || (subSec == SUB_MAX)));

  // R6
  sec_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !atBoundary |=> $stable(secCount));

endmodule

// File: rtl/rtcTrimSecond.sv
module rtcTrimSecond
  import rtcTrimPkg::*;
#(
  parameter int NOM_LOG2 = 15,
  parameter int SEC_W    = 32,
  localparam int COARSE_W = NOM_LOG2 + 2,
  localparam int TERM_W   = COARSE_W + 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sleepMode,
  input  logic                trimWr,
  input  logic [COARSE_W-1:0] trimCoarseWr,
  input  logic [1:0]          trimFineWr,
  input  logic                secWr,
  input  logic [SEC_W-1:0]    secWrData,
  input  logic                subRestart,
  output logic                secPulse,
  output logic [SEC_W-1:0]    secCount,
  output logic [7:0]          subSec,
  output logic [COARSE_W-1:0] trimCoarse,
  output logic [1:0]          trimFine
);

  rtcStrobe_t          strobe;
  logic [TERM_W-1:0]   nextTerm;
  logic [SEC_W-1:0]    pendSec;
  logic                atBoundary;

  rtcTrimCtrl #(.NOM_LOG2(NOM_LOG2), .SEC_W(SEC_W)) uCtrl (
    .clk          (clk),
    .rstN         (rstN),
    .sleepMode    (sleepMode),
    .trimWr       (trimWr),
    .trimCoarseWr (trimCoarseWr),
    .trimFineWr   (trimFineWr),
    .secWr        (secWr),
    .secWrData    (secWrData),
    .subRestart   (subRestart),
    .atBoundary   (atBoundary),
    .strobe       (strobe),
    .nextTerm     (nextTerm),
    .pendSec      (pendSec),
    .trimCoarse   (trimCoarse),
    .trimFine     (trimFine)
  );

  rtcTrimDatapath #(.NOM_LOG2(NOM_LOG2), .SEC_W(SEC_W)) uPath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .nextTerm   (nextTerm),
    .pendSec    (pendSec),
    .atBoundary (atBoundary),
    .secPulse   (secPulse),
    .secCount   (secCount),
    .subSec     (subSec)
  );

endmodule

// File: tb/sim_rtcTrimSecond.sv
module sim_rtcTrimSecond;

  localparam int NOM_LOG2 = 9;
  localparam int SEC_W    = 16;
  localparam int NOM      = 1 << NOM_LOG2;
  localparam int T_NOM    = 8 * NOM;
  localparam int CW       = NOM_LOG2 + 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sleepMode = 1'b0;
  logic trimWr = 1'b0;
  logic [CW-1:0] trimCoarseWr = '0;
  logic [1:0] trimFineWr = '0;
  logic secWr = 1'b0;
  logic [SEC_W-1:0] secWrData = '0;
  logic subRestart = 1'b0;
  logic secPulse;
  logic [SEC_W-1:0] secCount;
  logic [7:0] subSec;
  logic [CW-1:0] trimCoarse;
  logic [1:0] trimFine;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  rtcTrimSecond #(.NOM_LOG2(NOM_LOG2), .SEC_W(SEC_W)) u0 (
    .clk(clk), .rstN(rstN), .sleepMode(sleepMode),
    .trimWr(trimWr), .trimCoarseWr(trimCoarseWr), .trimFineWr(trimFineWr),
    .secWr(secWr), .secWrData(secWrData), .subRestart(subRestart),
    .secPulse(secPulse), .secCount(secCount), .subSec(subSec),
    .trimCoarse(trimCoarse), .trimFine(trimFine)
  );

  function automatic int lenLo(int term); return term >> 3; endfunction
  function automatic int lenHi(int term); return (term % 8 == 0) ? (term >> 3) : (term >> 3) + 1; endfunction
  function automatic int subExp(int j);
    int v = 255 - (j >> (NOM_LOG2 - 8));
    return (v < 0) ? 0 : v;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic waitPulse(output int len);
    len = 0;
    do begin
      @(negedge clk);
      len++;
    end while (!secPulse && len < 100000);
  endtask

  task automatic measureEight(output int total, output int mn, output int mx);
    int len;
    total = 0; mn = 1 << 30; mx = 0;
    for (int s = 0; s < 8; s++) begin
      waitPulse(len);
      total += len;
      if (len < mn) mn = len;
      if (len > mx) mx = len;
    end
  endtask

  task automatic writeTrim(int term);
    trimWr = 1'b1;
    trimCoarseWr = CW'(term >> 2);
    trimFineWr = 2'(term & 3);
    @(negedge clk);
    trimWr = 1'b0;
  endtask

  task automatic commitTrim(int term);
    int len;
    int oldC;
    waitPulse(len);
    repeat (40) @(negedge clk);
    oldC = int'(trimCoarse);
    writeTrim(term);
    chk(int'(trimCoarse) == oldC, "R5 trim held before boundary", int'(trimCoarse), oldC);
    waitPulse(len);
    chk(int'(trimCoarse) == (term >> 2) && int'(trimFine) == (term & 3),
        "R5 trim active after boundary", int'({trimCoarse, trimFine}), term);
  endtask

  task automatic runTrim(int term);
    int total, mn, mx;
    commitTrim(term);
    measureEight(total, mn, mx);
    chk(total == term, "R1 eight-second total", total, term);
    chk(mn >= lenLo(term), "R2 shortest second", mn, lenLo(term));
    chk(mx <= lenHi(term), "R2 longest second", mx, lenHi(term));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int len, total, mn, mx, old, term;
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    // R3 reset state
    chk(secCount == 0 && subSec == 255 && !secPulse, "R3 reset outputs",
        int'(secCount), 0);
    chk(int'(trimCoarse) == (1 << (NOM_LOG2 + 1)) && trimFine == 0, "R3 reset trim",
        int'({trimCoarse, trimFine}), T_NOM);
    // the reset-release negedge is excluded: first pulse at NOM
    waitPulse(len);
    chk(len == NOM, "R3 first second length", len, NOM);
    // R1 R2 default term
    measureEight(total, mn, mx);
    chk(total == T_NOM, "R1 default eight-second total", total, T_NOM);
    chk(mn == NOM && mx == NOM, "R2 default seconds", mx, NOM);
    // R7 sub-second countdown in a nominal second (now at a pulse)
    chk(subSec == 255, "R7 reload at pulse", int'(subSec), 255);
    repeat (100) @(negedge clk);
    chk(int'(subSec) == subExp(100), "R7 mid-second", int'(subSec), subExp(100));
    repeat (NOM - 1 - 100) @(negedge clk);
    chk(int'(subSec) == 0 && !secPulse, "R7 last cycle reaches zero", int'(subSec), 0);
    @(negedge clk);
    chk(secPulse, "R4 pulse at nominal spacing", int'(secPulse), 1);
    @(negedge clk);
    chk(!secPulse, "R4 pulse one cycle", int'(secPulse), 0);
    // R8 restart mid-second, boundary unmoved
    len = 1;
    repeat (100) begin @(negedge clk); len++; end
    subRestart = 1'b1;
    @(negedge clk); len++;
    subRestart = 1'b0;
    chk(subSec == 255, "R8 restart to 255", int'(subSec), 255);
    repeat (20) begin @(negedge clk); len++; end
    chk(int'(subSec) == subExp(20), "R8 countdown after restart", int'(subSec), subExp(20));
    while (!secPulse) begin @(negedge clk); len++; end
    chk(len == NOM, "R8 boundary unchanged", len, NOM);
    // R6 seconds write
    repeat (30) @(negedge clk);
    old = int'(secCount);
    secWr = 1'b1; secWrData = 16'hBEEF;
    @(negedge clk);
    secWr = 1'b0;
    chk(int'(secCount) == old, "R6 held before boundary", int'(secCount), old);
    waitPulse(len);
    chk(secCount == 16'hBEEF, "R6 loaded at boundary", int'(secCount), 'hBEEF);
    waitPulse(len);
    chk(secCount == 16'hBEF0, "R6 counts after load", int'(secCount), 'hBEF0);
    // directed trims: slow-down like term and a speed-up like term
    runTrim(T_NOM + 3);
    // R9 sleep with a trim active
    sleepMode = 1'b1;
    waitPulse(len);
    measureEight(total, mn, mx);
    chk(total == T_NOM && mn == NOM && mx == NOM, "R9 sleep nominal seconds", total, T_NOM);
    chk(int'({trimCoarse, trimFine}) == T_NOM + 3, "R9 trim kept in sleep",
        int'({trimCoarse, trimFine}), T_NOM + 3);
    sleepMode = 1'b0;
    waitPulse(len);
    measureEight(total, mn, mx);
    chk(total == T_NOM + 3, "R9 trim resumes after sleep", total, T_NOM + 3);
    runTrim(T_NOM - 3);
    // R7 saturation in a long second
    commitTrim(T_NOM + 8);
    repeat (NOM) @(negedge clk);
    chk(int'(subSec) == 0 && !secPulse, "R7 holds at zero", int'(subSec), 0);
    @(negedge clk);
    chk(secPulse && subSec == 255, "R7 reload after long second", int'(subSec), 255);
    // random terms around nominal
    for (int i = 0; i < 6; i++) begin
      term = T_NOM - 20 + int'($urandom_range(40));
      runTrim(term);
    end
    runTrim(T_NOM + 1);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule